// File: doc/BRIEF.md
# Merging Miss Status Holding Table

This block tracks cache-line misses that are still outstanding toward the next memory level. Each entry is keyed by a block address. It holds an ordered list of opaque request tokens that have merged onto that miss, plus a flag recording whether any of those requests was atomic. A lookup address is compared against every entry in one cycle. The compare yields a hit indication and a "cannot accept" indication, and the surrounding cache uses these two results to decide whether a new request may be added.

When the line for a block returns, the cache raises a fill for that block. The table reports the entry's atomic flag in the same cycle and places the entry in the ready slot. From the next cycle on, the table presents the oldest merged token of that entry, one token per drain strobe. The entry is released only when its list becomes empty. A small controller with two states, IDLE and DRAIN, governs the ready slot. IDLE moves to DRAIN on a fill (transition FILL_ACCEPT). DRAIN stays in DRAIN while tokens remain (transition DRAIN_MORE). DRAIN returns to IDLE on the pop of the last token (transition DRAIN_DONE). A fill is legal only in IDLE, so the ready queue is never deeper than one entry.

Top module: `miss_merge_table`

## Requirements
- R1: After reset no entry exists: `req_hit` is 0, `req_full` is 0 for any address, and `drain_ready` is 0.
- R2: `req_hit` is 1 exactly when a live entry holds the block address on `req_addr`.
- R3: For an address that has an entry, `req_full` is 1 exactly when that entry already holds MERGE_SLOTS tokens.
- R4: For an address that has no entry, `req_full` is 1 exactly when all NUM_ENTRIES entries are live.
- R5: A strobe on `add_en` appends `add_id` to the tail of the address's list, and allocates a fresh entry if none exists. Tokens drain oldest first.
- R6: During a fill, `fill_atomic` is 1 when any token added to that entry since its allocation had `add_atomic` set, and 0 otherwise. The flag clears when the entry is released.
- R7: A fill in IDLE (FILL_ACCEPT) makes `drain_ready` 1 from the next cycle, with `drain_id` showing the entry's oldest token.
- R8: Each `drain_en` while `drain_ready` is 1 removes one token. The token that follows appears in the next cycle (DRAIN_MORE). After the last token (DRAIN_DONE), `drain_ready` is 0 and the address no longer hits.
- R9: A fill raised while `drain_ready` is 1 has no effect: no other entry is queued, and that entry stays live.
- R10: An add that merges into the entry being drained, in the same cycle as its last pop, keeps the entry live, and the new token drains next.
- R11: An add while `req_full` is 1, and a fill in IDLE for an address with no entry, are protocol errors that the design flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | ADDR_W | Block address for lookup and add |
| req_hit | output | 1 | An entry for `req_addr` exists |
| req_full | output | 1 | A request for `req_addr` cannot be tracked |
| add_en | input | 1 | Add `add_id` under `req_addr` |
| add_id | input | ID_W | Opaque request token |
| add_atomic | input | 1 | Added request is atomic |
| fill_en | input | 1 | Line for `fill_addr` has returned |
| fill_addr | input | ADDR_W | Block address of the returned line |
| fill_atomic | output | 1 | Atomic flag of the entry for `fill_addr` |
| drain_ready | output | 1 | A filled entry is draining (busy) |
| drain_id | output | ID_W | Oldest token of the draining entry |
| drain_en | input | 1 | Consume `drain_id` |

## Verification
A corrupt merge FIFO pointer or count shows up on the next drain. Tokens then come out in the wrong order, repeat, or are dropped, and `drain_ready` falls too early or too late, all visible within the few cycles the entry takes to drain. A stuck valid bit or stale atomic flag shows up at once on `req_hit`, `req_full` or `fill_atomic` for that address. The bench therefore probes addresses both before and after every drain, not only at the end of a scenario.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } drain_state_e;

endpackage

// File: rtl/mmt_match.sv
module mmt_match #(
    parameter int N      = 4,
    parameter int ADDR_W = 16,
    localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0]               live,
    input  logic [N-1:0][ADDR_W-1:0]   tags,
    input  logic [ADDR_W-1:0]          key,
    output logic                       hit,
    output logic [IW-1:0]              hit_idx
);

    logic [N-1:0] eq_vec;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign eq_vec[g] = live[g] && (tags[g] == key);
        end
    endgenerate

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq_vec[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |eq_vec;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eq_vec)); // R2

endmodule

// File: rtl/mmt_entry.sv
module mmt_entry #(
    parameter int SLOTS  = 3,
    parameter int ID_W   = 8,
    parameter int ADDR_W = 16,
    localparam int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW    = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic              push_atomic,
    input  logic              pop,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [CW-1:0]     count,
    output logic [ID_W-1:0]   head_id,
    output logic              atomic
);

    logic [ID_W-1:0] slot_q [SLOTS];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic            release_now;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + PW'(1);
    endfunction

    assign release_now = pop && (count == CW'(1)) && !push;

    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr] <= push_id;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            addr   <= '0;
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            atomic <= 1'b0;
        end else begin
            if (alloc) begin
                valid <= 1'b1;
                addr  <= alloc_addr;
            end else if (release_now) begin
                valid <= 1'b0;
            end
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            if (alloc)                    atomic <= push_atomic;
            else if (push && push_atomic) atomic <= 1'b1;
            else if (release_now)         atomic <= 1'b0;
        end
    end

    assign head_id = slot_q[rd_ptr];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(SLOTS)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CW'(SLOTS))); // R11
    AST_FREE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        release_now |=> !valid); // R8
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (valid && count != '0)); // R8

endmodule

// File: rtl/mmt_drain_fsm.sv
module mmt_drain_fsm
    import mmt_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_en,
    input  logic          fill_hit,
    input  logic [IW-1:0] fill_idx,
    input  logic          pop_req,
    input  logic          head_last,
    output logic          busy,
    output logic          pop_fire,
    output logic [IW-1:0] head_idx
);

    drain_state_e state_q, state_d;
    logic [IW-1:0] head_d;

    always_comb begin
        state_d = state_q;
        head_d  = head_idx;
        unique case (state_q)
            ST_IDLE: begin
                if (fill_en && fill_hit) begin   // FILL_ACCEPT
                    state_d = ST_DRAIN;
                    head_d  = fill_idx;
                end
            end
            ST_DRAIN: begin
                if (pop_req && head_last) begin  // DRAIN_DONE
                    state_d = ST_IDLE;
                end                              // else DRAIN_MORE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            head_idx <= '0;
        end else begin
            state_q  <= state_d;
            head_idx <= head_d;
        end
    end

    always_comb begin
        busy     = 1'b0;
        pop_fire = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DRAIN: begin
                busy     = 1'b1;
                pop_fire = pop_req;
            end
            default: ;
        endcase
    end

    AST_FILL_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && state_q == ST_IDLE) |-> fill_hit); // R11
    AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && pop_req && head_last) |=> state_q == ST_IDLE); // R8
    AST_BUSY_FILL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !(pop_req && head_last)) |=> $stable(head_idx)); // R9

endmodule

// File: rtl/miss_merge_table.sv
module miss_merge_table #(
    parameter int NUM_ENTRIES = 4,
    parameter int MERGE_SLOTS = 3,
    parameter int ADDR_W      = 16,
    parameter int ID_W        = 8,
    localparam int IW         = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CW         = $clog2(MERGE_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_hit,
    output logic              req_full,
    input  logic              add_en,
    input  logic [ID_W-1:0]   add_id,
    input  logic              add_atomic,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              fill_atomic,
    output logic              drain_ready,
    output logic [ID_W-1:0]   drain_id,
    input  logic              drain_en
);

    logic [NUM_ENTRIES-1:0]             live_vec;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tag_vec;
    logic [NUM_ENTRIES-1:0][CW-1:0]     cnt_vec;
    logic [NUM_ENTRIES-1:0][ID_W-1:0]   head_vec;
    logic [NUM_ENTRIES-1:0]             atom_vec;
    logic [NUM_ENTRIES-1:0]             alloc_vec;
    logic [NUM_ENTRIES-1:0]             push_vec;
    logic [NUM_ENTRIES-1:0]             pop_vec;

    logic [IW-1:0] req_idx, fill_idx, free_idx, head_idx;
    logic          fill_hit, free_found, all_live;
    logic          pop_fire, head_last;

    mmt_match #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_req_match (
        .clk(clk), .rst_n(rst_n), .live(live_vec), .tags(tag_vec),
        .key(req_addr), .hit(req_hit), .hit_idx(req_idx)
    );

    mmt_match #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_fill_match (
        .clk(clk), .rst_n(rst_n), .live(live_vec), .tags(tag_vec),
        .key(fill_addr), .hit(fill_hit), .hit_idx(fill_idx)
    );

    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!live_vec[i]) begin
                free_idx   = IW'(i);
                free_found = 1'b1;
            end
        end
    end

    assign all_live    = &live_vec;
    assign req_full    = req_hit ? (cnt_vec[req_idx] == CW'(MERGE_SLOTS)) : all_live;
    assign fill_atomic = fill_hit && atom_vec[fill_idx];
    assign drain_id    = head_vec[head_idx];
    assign head_last   = (cnt_vec[head_idx] == CW'(1)) && !push_vec[head_idx];

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_ent
            assign alloc_vec[g] = add_en && !req_hit && free_found && (free_idx == IW'(g));
            assign push_vec[g]  = add_en && (req_hit ? (req_idx == IW'(g)) : alloc_vec[g]);
            assign pop_vec[g]   = pop_fire && (head_idx == IW'(g));

            mmt_entry #(.SLOTS(MERGE_SLOTS), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_entry (
                .clk(clk), .rst_n(rst_n),
                .alloc(alloc_vec[g]), .alloc_addr(req_addr),
                .push(push_vec[g]), .push_id(add_id), .push_atomic(add_atomic),
                .pop(pop_vec[g]),
                .valid(live_vec[g]), .addr(tag_vec[g]), .count(cnt_vec[g]),
                .head_id(head_vec[g]), .atomic(atom_vec[g])
            );
        end
    endgenerate

    mmt_drain_fsm #(.N(NUM_ENTRIES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_hit(fill_hit), .fill_idx(fill_idx),
        .pop_req(drain_en), .head_last(head_last),
        .busy(drain_ready), .pop_fire(pop_fire), .head_idx(head_idx)
    );

    AST_ADD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |-> !req_full); // R11
    AST_READY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        drain_ready |-> live_vec[head_idx]); // R7
    AST_ALLOC_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !req_hit) |=> req_hit || $past(req_addr) != req_addr); // R5
    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec)); // R5

endmodule

// File: tb/miss_merge_table_bench.sv
`timescale 1ns/100ps
module miss_merge_table_bench;

    localparam int N  = 4;
    localparam int S  = 3;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_hit, req_full;
    logic          add_en = 1'b0;
    logic [DW-1:0] add_id = '0;
    logic          add_atomic = 1'b0;
    logic          fill_en = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic          fill_atomic;
    logic          drain_ready;
    logic [DW-1:0] drain_id;
    logic          drain_en = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    miss_merge_table #(.NUM_ENTRIES(N), .MERGE_SLOTS(S), .ADDR_W(AW), .ID_W(DW)) u_miss_merge_table (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_hit(req_hit), .req_full(req_full),
        .add_en(add_en), .add_id(add_id), .add_atomic(add_atomic),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_atomic(fill_atomic),
        .drain_ready(drain_ready), .drain_id(drain_id), .drain_en(drain_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic eh, input logic ef, input string tag);
        req_addr = a;
        #1;
        chk({tag, " hit"}, 32'(req_hit), 32'(eh));
        chk({tag, " full"}, 32'(req_full), 32'(ef));
    endtask

    task automatic do_add(input logic [AW-1:0] a, input logic [DW-1:0] id, input logic at);
        req_addr = a; add_id = id; add_atomic = at; add_en = 1'b1;
        @(negedge clk);
        add_en = 1'b0; add_atomic = 1'b0;
    endtask

    task automatic do_fill(input logic [AW-1:0] a, input logic ea, input string tag);
        fill_addr = a; fill_en = 1'b1;
        #1;
        chk({tag, " fill_atomic"}, 32'(fill_atomic), 32'(ea));
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_pop(input logic [DW-1:0] eid, input string tag);
        #1;
        chk({tag, " ready"}, 32'(drain_ready), 32'd1);
        chk({tag, " id"}, 32'(drain_id), 32'(eid));
        drain_en = 1'b1;
        @(negedge clk);
        drain_en = 1'b0;
    endtask

    task automatic expect_idle(input string tag);
        #1;
        chk({tag, " idle"}, 32'(drain_ready), 32'd0);
    endtask

    // R1
    task automatic t_reset();
        probe(16'h0100, 1'b0, 1'b0, "R1 reset");
        expect_idle("R1 reset");
    endtask

    // R2 R3 R5 R7 R8
    task automatic t_merge_order();
        do_add(16'h0A00, 8'd1, 1'b0);
        probe(16'h0A00, 1'b1, 1'b0, "R2 after first add");
        probe(16'h0B00, 1'b0, 1'b0, "R2 other addr");
        do_add(16'h0A00, 8'd2, 1'b0);
        probe(16'h0A00, 1'b1, 1'b0, "R3 two of three");
        do_add(16'h0A00, 8'd3, 1'b0);
        probe(16'h0A00, 1'b1, 1'b1, "R3 merge limit");
        expect_idle("R7 before fill");
        do_fill(16'h0A00, 1'b0, "R6 plain");
        do_pop(8'd1, "R7 first");
        do_pop(8'd2, "R5 second");
        do_pop(8'd3, "R8 third");
        expect_idle("R8 done");
        probe(16'h0A00, 1'b0, 1'b0, "R8 released");
    endtask

    // R4
    task automatic t_capacity();
        for (int i = 0; i < N; i++) do_add(16'(16'h1000 + i * 16'h0100), 8'(40 + i), 1'b0);
        probe(16'h2000, 1'b0, 1'b1, "R4 table full new addr");
        probe(16'h1000, 1'b1, 1'b0, "R3 existing addr when table full");
        for (int i = 0; i < N; i++) begin
            do_fill(16'(16'h1000 + i * 16'h0100), 1'b0, "R4 drain");
            do_pop(8'(40 + i), "R4 drain");
        end
        probe(16'h2000, 1'b0, 1'b0, "R4 space again");
    endtask

    // R6
    task automatic t_atomic();
        do_add(16'h0C00, 8'd7, 1'b0);
        do_add(16'h0C00, 8'd8, 1'b1);
        do_fill(16'h0C00, 1'b1, "R6 atomic merged");
        do_pop(8'd7, "R6 drain");
        do_pop(8'd8, "R6 drain");
        do_add(16'h0C00, 8'd9, 1'b0);
        do_fill(16'h0C00, 1'b0, "R6 flag cleared on release");
        do_pop(8'd9, "R6 drain");
        expect_idle("R6 end");
    endtask

    // R9
    task automatic t_busy_fill();
        do_add(16'h0D00, 8'd10, 1'b0);
        do_add(16'h0D00, 8'd11, 1'b0);
        do_add(16'h0E00, 8'd20, 1'b0);
        do_fill(16'h0D00, 1'b0, "R9 first fill");
        do_pop(8'd10, "R9 pop");
        do_fill(16'h0E00, 1'b0, "R9 fill while busy");
        do_pop(8'd11, "R9 original entry continues");
        expect_idle("R9 busy fill not queued");
        probe(16'h0E00, 1'b1, 1'b0, "R9 entry still live");
        do_fill(16'h0E00, 1'b0, "R9 refill");
        do_pop(8'd20, "R9 late drain");
        expect_idle("R9 end");
    endtask

    // R10
    task automatic t_merge_on_last();
        do_add(16'h0F00, 8'd30, 1'b0);
        do_fill(16'h0F00, 1'b0, "R10 fill");
        #1;
        chk("R10 head", 32'(drain_id), 32'd30);
        req_addr = 16'h0F00; add_id = 8'd31; add_en = 1'b1; drain_en = 1'b1;
        @(negedge clk);
        add_en = 1'b0; drain_en = 1'b0;
        do_pop(8'd31, "R10 merged token drains");
        expect_idle("R10 end");
        probe(16'h0F00, 1'b0, 1'b0, "R10 released");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge_order();
        t_capacity();
        t_atomic();
        t_busy_fill();
        t_merge_on_last();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule